// File: doc/BRIEF.md
# DRAM Idle-Driven Low-Power Sequencer

This block decides when a DRAM controller moves the attached memory into a low-power state and when it brings it back. It watches a transaction-arrival level and a pending-work flag, and keeps one idle counter. The counter is compared against three programmable idle limits: power-down, self-refresh and clock stop. It also accepts a software self-refresh request, a software deep power-down request, and a hardware low-power request that it answers with an acknowledge or a denial. Its output is a single command request with an operation code, which the command scheduler takes by raising an acknowledge. While the memory is anywhere other than normal operation, a stall output holds new traffic back. A requester that sees the stall keeps its arrival level asserted until the stall clears.

The sequencer is one state machine with thirteen states. `ST_NORM` is normal operation. Each low-power mode has three states: an entry state that requests the entry command (`ST_PD_IN`, `ST_SR_IN`, `ST_CS_IN`, `ST_DP_IN`), a resident state (`ST_PD`, `ST_SR`, `ST_CS`, `ST_DP`) and an exit state that requests the exit command (`ST_PD_OUT`, `ST_SR_OUT`, `ST_CS_OUT`, `ST_DP_OUT`).

The transitions are as follows:
- From `ST_NORM`, with no arrival, the machine moves to an entry state. The candidates are checked in the order deep power-down, self-refresh, clock stop, power-down.
- An entry state moves to its resident state on acknowledge.
- A resident state moves to its exit state on its wake condition.
- An exit state returns to `ST_NORM` on acknowledge.
- A self-refresh or deep power-down trigger seen in `ST_PD` or `ST_CS` takes the exit path first. The deeper state is then entered from `ST_NORM`.

A register beside the state records why self-refresh was entered: idle timeout, software or hardware.

Top module: `dram_lp_ctrl`

## Requirements
- R1: After reset, `lp_mode` is 0 (normal), and `cmd_req`, `traffic_stall`, `hw_lp_ack` and `hw_lp_deny` are all low.
- R2: A cycle is idle when both `txn_arrive` and `work_pending` are low. When `cfg_pd_en` is 1, the idle count reaches `cfg_pd_idle` and the current cycle is idle, the block requests power-down entry (op 0). On acknowledge it enters power-down.
- R3: In power-down, clock stop, or self-refresh entered by idle timeout, an arrival moves the block to its exit request (PD exit op 1, SR exit op 3, CS exit op 5) on the following clock edge. `traffic_stall` stays high until that exit is acknowledged.
- R4: `cmd_req` stays high with `cmd_op` unchanged until `cmd_ack` is sampled high. The op codes are: 0 PD entry, 1 PD exit, 2 SR entry, 3 SR exit, 4 CS entry, 5 CS exit, 6 DPD entry, 7 DPD exit.
- R5: When `cfg_sr_en` is 1, idle self-refresh uses its own limit `cfg_sr_idle`. If the block is in power-down when that limit is reached, it first issues a power-down exit and then a self-refresh entry.
- R6: While `sw_sr_req` is high, self-refresh is entered and kept regardless of arrivals. Once the request drops, self-refresh is exited.
- R7: A high `hw_lp_req` is denied (`hw_lp_deny` high) while `work_pending` is high. Otherwise it leads to self-refresh. `hw_lp_ack` is high only while resident in self-refresh with the request high. When the request drops, self-refresh is exited.
- R8: Clock stop is entered on idle timeout only when `cfg_mem_kind` is 1 or 2 (the low-power DRAM kinds). With kind 0 it never happens.
- R9: Deep power-down is entered only on `sw_dpd_req` with `cfg_mem_kind` equal to 1. Arrivals do not wake it. It is exited only when `sw_dpd_req` drops.
- R10: Each automatic mechanism has its own enable. When several are due at once, the priority is deep power-down, then self-refresh, then clock stop, then power-down.
- R11: `lp_mode` reports the mode the memory is in: 0 normal, 1 power-down, 2 self-refresh, 3 clock stop, 4 deep power-down. During an entry request it still reads 0. During an exit request it still reads the low-power mode.
- R12: The idle count clears on any cycle with an arrival or pending work, and it saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_arrive | input | 1 | Transaction present; held while stalled |
| work_pending | input | 1 | Controller still holds queued work |
| cfg_mem_kind | input | 2 | 0 standard DDR, 1 LPDDR2, 2 LPDDR3 |
| cfg_pd_en | input | 1 | Enable idle power-down |
| cfg_sr_en | input | 1 | Enable idle self-refresh |
| cfg_cs_en | input | 1 | Enable idle clock stop |
| cfg_pd_idle | input | CNT_W | Idle cycles before power-down |
| cfg_sr_idle | input | CNT_W | Idle cycles before self-refresh |
| cfg_cs_idle | input | CNT_W | Idle cycles before clock stop |
| sw_sr_req | input | 1 | Software self-refresh request (level) |
| sw_dpd_req | input | 1 | Software deep power-down request (level) |
| hw_lp_req | input | 1 | Hardware low-power request (level) |
| hw_lp_ack | output | 1 | Hardware request granted, self-refresh resident |
| hw_lp_deny | output | 1 | Hardware request refused, work pending |
| cmd_req | output | 1 | Command request toward the scheduler |
| cmd_op | output | 3 | Requested operation code |
| cmd_ack | input | 1 | Scheduler accepts the request |
| lp_mode | output | 3 | Current memory mode |
| traffic_stall | output | 1 | Hold new traffic |

## Verification
The bench builds the block with `CNT_W` = 5. This puts the counter ceiling of 31 within a few dozen cycles, so a self-refresh limit at the ceiling is shown to be reachable only through saturation. Idle limits of 4, 6 and 12 let power-down, clock stop and the power-down-then-self-refresh path all occur in one short run. Two settings deliberately make several mechanisms due in the same cycle, so the arbitration order is exercised. The bench scheduler answers after a latency that the bench changes between 0, 2 and 4 cycles, which covers both an immediate acknowledge and a long hold of a request.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    typedef enum logic [3:0] {
        ST_NORM,
        ST_PD_IN, ST_PD, ST_PD_OUT,
        ST_SR_IN, ST_SR, ST_SR_OUT,
        ST_CS_IN, ST_CS, ST_CS_OUT,
        ST_DP_IN, ST_DP, ST_DP_OUT
    } lp_state_e;

    typedef enum logic [2:0] {
        OP_PD_IN  = 3'd0, OP_PD_OUT = 3'd1,
        OP_SR_IN  = 3'd2, OP_SR_OUT = 3'd3,
        OP_CS_IN  = 3'd4, OP_CS_OUT = 3'd5,
        OP_DP_IN  = 3'd6, OP_DP_OUT = 3'd7
    } lp_op_e;

    typedef enum logic [2:0] {
        MD_NORMAL  = 3'd0,
        MD_PWRDN   = 3'd1,
        MD_SELFREF = 3'd2,
        MD_CLKSTOP = 3'd3,
        MD_DEEPPD  = 3'd4
    } lp_mode_e;

    typedef enum logic [1:0] {
        CAUSE_AUTO = 2'd0,
        CAUSE_SW   = 2'd1,
        CAUSE_HW   = 2'd2
    } sr_cause_e;

    localparam int TMR_PD  = 0;
    localparam int TMR_SR  = 1;
    localparam int TMR_CS  = 2;
    localparam int NUM_TMR = 3;

    localparam logic [1:0] KIND_STD = 2'd0;
    localparam logic [1:0] KIND_LP2 = 2'd1;
    localparam logic [1:0] KIND_LP3 = 2'd2;

endpackage

// File: rtl/dlp_idle_count.sv
module dlp_idle_count #(
    parameter int CNT_W   = 8,
    parameter int NUM_TMR = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            busy,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   thr,
    input  logic [NUM_TMR-1:0]              en,
    output logic [NUM_TMR-1:0]              hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_cmp
        assign hit[g] = en[g] && (cnt_q >= thr[g]);
    end

    // R12
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == '0));

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !busy) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dlp_fsm.sv
module dlp_fsm
    import dlp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_arrive,
    input  logic               work_pending,
    input  logic [1:0]         mem_kind,
    input  logic               sw_sr_req,
    input  logic               sw_dpd_req,
    input  logic               hw_lp_req,
    input  logic [NUM_TMR-1:0] hit,
    input  logic               cmd_ack,
    output logic               cmd_req,
    output logic [2:0]         cmd_op,
    output logic [2:0]         lp_mode,
    output logic               traffic_stall,
    output logic               hw_lp_ack,
    output logic               hw_lp_deny
);
    lp_state_e state_q, state_d;
    sr_cause_e cause_q, cause_d;

    logic idle_now, dp_trig, sr_sw, sr_hw, sr_auto, sr_trig, cs_trig, pd_trig, escalate;

    always_comb begin
        idle_now = !txn_arrive && !work_pending;
        dp_trig  = sw_dpd_req && (mem_kind == KIND_LP2);
        sr_sw    = sw_sr_req;
        sr_hw    = hw_lp_req && !work_pending;
        sr_auto  = idle_now && hit[TMR_SR];
        sr_trig  = sr_sw || sr_hw || sr_auto;
        cs_trig  = idle_now && hit[TMR_CS] &&
                   ((mem_kind == KIND_LP2) || (mem_kind == KIND_LP3));
        pd_trig  = idle_now && hit[TMR_PD];
        escalate = dp_trig || sr_trig;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_NORM: begin
                if (!txn_arrive) begin
                    if (dp_trig) begin
                        state_d = ST_DP_IN;
                    end else if (sr_trig) begin
                        state_d = ST_SR_IN;
                        cause_d = sr_sw ? CAUSE_SW : (sr_hw ? CAUSE_HW : CAUSE_AUTO);
                    end else if (cs_trig) begin
                        state_d = ST_CS_IN;
                    end else if (pd_trig) begin
                        state_d = ST_PD_IN;
                    end
                end
            end
            ST_PD_IN:  if (cmd_ack) state_d = ST_PD;
            ST_PD:     if (txn_arrive || escalate) state_d = ST_PD_OUT;
            ST_PD_OUT: if (cmd_ack) state_d = ST_NORM;
            ST_SR_IN:  if (cmd_ack) state_d = ST_SR;
            ST_SR: begin
                if (!sw_sr_req && (txn_arrive || cause_q == CAUSE_SW ||
                    (cause_q == CAUSE_HW && !hw_lp_req)))
                    state_d = ST_SR_OUT;
            end
            ST_SR_OUT: if (cmd_ack) state_d = ST_NORM;
            ST_CS_IN:  if (cmd_ack) state_d = ST_CS;
            ST_CS:     if (txn_arrive || escalate) state_d = ST_CS_OUT;
            ST_CS_OUT: if (cmd_ack) state_d = ST_NORM;
            ST_DP_IN:  if (cmd_ack) state_d = ST_DP;
            ST_DP:     if (!sw_dpd_req) state_d = ST_DP_OUT;
            ST_DP_OUT: if (cmd_ack) state_d = ST_NORM;
            default:   state_d = ST_NORM;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORM;
            cause_q <= CAUSE_AUTO;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // outputs
    always_comb begin
        cmd_req = 1'b0;
        cmd_op  = OP_PD_IN;
        lp_mode = MD_NORMAL;
        unique case (state_q)
            ST_NORM:   ;
            ST_PD_IN:  begin cmd_req = 1'b1; cmd_op = OP_PD_IN; end
            ST_PD:     lp_mode = MD_PWRDN;
            ST_PD_OUT: begin cmd_req = 1'b1; cmd_op = OP_PD_OUT; lp_mode = MD_PWRDN; end
            ST_SR_IN:  begin cmd_req = 1'b1; cmd_op = OP_SR_IN; end
            ST_SR:     lp_mode = MD_SELFREF;
            ST_SR_OUT: begin cmd_req = 1'b1; cmd_op = OP_SR_OUT; lp_mode = MD_SELFREF; end
            ST_CS_IN:  begin cmd_req = 1'b1; cmd_op = OP_CS_IN; end
            ST_CS:     lp_mode = MD_CLKSTOP;
            ST_CS_OUT: begin cmd_req = 1'b1; cmd_op = OP_CS_OUT; lp_mode = MD_CLKSTOP; end
            ST_DP_IN:  begin cmd_req = 1'b1; cmd_op = OP_DP_IN; end
            ST_DP:     lp_mode = MD_DEEPPD;
            ST_DP_OUT: begin cmd_req = 1'b1; cmd_op = OP_DP_OUT; lp_mode = MD_DEEPPD; end
            default:   ;
        endcase
        traffic_stall = (state_q != ST_NORM);
        hw_lp_ack     = (state_q == ST_SR) && hw_lp_req;
        hw_lp_deny    = hw_lp_req && work_pending && (state_q != ST_SR);
    end

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

    // R3
    wake_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == MD_PWRDN && !cmd_req && txn_arrive) |=> (cmd_req && cmd_op == OP_PD_OUT));

    // R6
    sw_sr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR && sw_sr_req) |=> (lp_mode == MD_SELFREF && !cmd_req));

    // R9
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DP && sw_dpd_req) |=> (lp_mode == MD_DEEPPD && !cmd_req));

    // R7
    ack_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_lp_ack && hw_lp_deny));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode != MD_NORMAL) |-> traffic_stall);

endmodule

// File: rtl/dram_lp_ctrl.sv
module dram_lp_ctrl
    import dlp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_arrive,
    input  logic             work_pending,
    input  logic [1:0]       cfg_mem_kind,
    input  logic             cfg_pd_en,
    input  logic             cfg_sr_en,
    input  logic             cfg_cs_en,
    input  logic [CNT_W-1:0] cfg_pd_idle,
    input  logic [CNT_W-1:0] cfg_sr_idle,
    input  logic [CNT_W-1:0] cfg_cs_idle,
    input  logic             sw_sr_req,
    input  logic             sw_dpd_req,
    input  logic             hw_lp_req,
    output logic             hw_lp_ack,
    output logic             hw_lp_deny,
    output logic             cmd_req,
    output logic [2:0]       cmd_op,
    input  logic             cmd_ack,
    output logic [2:0]       lp_mode,
    output logic             traffic_stall
);
    logic [NUM_TMR-1:0][CNT_W-1:0] thr;
    logic [NUM_TMR-1:0]            tmr_en;
    logic [NUM_TMR-1:0]            tmr_hit;
    logic                          busy;

    always_comb begin
        thr[TMR_PD]    = cfg_pd_idle;
        thr[TMR_SR]    = cfg_sr_idle;
        thr[TMR_CS]    = cfg_cs_idle;
        tmr_en[TMR_PD] = cfg_pd_en;
        tmr_en[TMR_SR] = cfg_sr_en;
        tmr_en[TMR_CS] = cfg_cs_en;
        busy           = txn_arrive || work_pending;
    end

    dlp_idle_count #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) i_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .thr   (thr),
        .en    (tmr_en),
        .hit   (tmr_hit)
    );

    dlp_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .txn_arrive    (txn_arrive),
        .work_pending  (work_pending),
        .mem_kind      (cfg_mem_kind),
        .sw_sr_req     (sw_sr_req),
        .sw_dpd_req    (sw_dpd_req),
        .hw_lp_req     (hw_lp_req),
        .hit           (tmr_hit),
        .cmd_ack       (cmd_ack),
        .cmd_req       (cmd_req),
        .cmd_op        (cmd_op),
        .lp_mode       (lp_mode),
        .traffic_stall (traffic_stall),
        .hw_lp_ack     (hw_lp_ack),
        .hw_lp_deny    (hw_lp_deny)
    );

endmodule

// File: tb/test_dram_lp_ctrl.sv
`timescale 1ns/100ps
module test_dram_lp_ctrl;
    localparam int CW   = 5;
    localparam int CMAX = 31;
    localparam int WD   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arrive = 0, pend = 0, sw_sr = 0, sw_dpd = 0, hw_req = 0, ack = 0;
    logic pd_en = 0, sr_en = 0, cs_en = 0;
    logic [1:0] kind = 2'd0;
    logic [CW-1:0] pd_thr = 5'd4, sr_thr = 5'd12, cs_thr = 5'd6;
    logic hw_ack, hw_deny, cmd_req, stall;
    logic [2:0] cmd_op, lp_mode;

    int total = 0, bad = 0, cyc = 0, ack_lat = 2;
    bit done = 0, seen_pd_out = 0;

    always #2 clk = ~clk;

    dram_lp_ctrl #(.CNT_W(CW)) i_dram_lp_ctrl (
        .clk(clk), .rst_n(rst_n), .txn_arrive(arrive), .work_pending(pend),
        .cfg_mem_kind(kind), .cfg_pd_en(pd_en), .cfg_sr_en(sr_en), .cfg_cs_en(cs_en),
        .cfg_pd_idle(pd_thr), .cfg_sr_idle(sr_thr), .cfg_cs_idle(cs_thr),
        .sw_sr_req(sw_sr), .sw_dpd_req(sw_dpd), .hw_lp_req(hw_req),
        .hw_lp_ack(hw_ack), .hw_lp_deny(hw_deny), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_ack(ack), .lp_mode(lp_mode), .traffic_stall(stall)
    );

    // behavioural reference: resident mode plus a transition phase
    int m_mode = 0, m_phase = 0, m_tgt = 0, m_cause = 0, m_cnt = 0, m_wait = 0;

    always @(posedge clk) begin
        bit idle, pd_t, cs_t, sra, srt, dpt, moved;
        if (!rst_n) begin
            m_mode = 0; m_phase = 0; m_tgt = 0; m_cause = 0; m_cnt = 0; m_wait = 0;
        end else begin
            idle  = !arrive && !pend;
            pd_t  = idle && pd_en && (m_cnt >= pd_thr);
            cs_t  = idle && cs_en && (kind == 2'd1 || kind == 2'd2) && (m_cnt >= cs_thr);
            sra   = idle && sr_en && (m_cnt >= sr_thr);
            srt   = sw_sr || (hw_req && !pend) || sra;
            dpt   = sw_dpd && (kind == 2'd1);
            moved = 0;
            if (m_phase == 1) begin
                if (ack) begin m_mode = m_tgt; m_phase = 0; moved = 1; end
            end else if (m_phase == 2) begin
                if (ack) begin m_mode = 0; m_phase = 0; moved = 1; end
            end else if (m_mode == 0) begin
                if (!arrive) begin
                    if (dpt) begin m_tgt = 4; m_phase = 1; moved = 1; end
                    else if (srt) begin
                        m_tgt = 2; m_phase = 1; moved = 1;
                        m_cause = sw_sr ? 1 : ((hw_req && !pend) ? 2 : 0);
                    end
                    else if (cs_t) begin m_tgt = 3; m_phase = 1; moved = 1; end
                    else if (pd_t) begin m_tgt = 1; m_phase = 1; moved = 1; end
                end
            end else if (m_mode == 1 || m_mode == 3) begin
                if (arrive || dpt || srt) begin m_phase = 2; moved = 1; end
            end else if (m_mode == 2) begin
                if (!sw_sr && (arrive || m_cause == 1 || (m_cause == 2 && !hw_req))) begin
                    m_phase = 2; moved = 1;
                end
            end else begin
                if (!sw_dpd) begin m_phase = 2; moved = 1; end
            end
            if (moved) m_wait = 0;
            else if (m_phase != 0) m_wait++;
            m_cnt = idle ? ((m_cnt == CMAX) ? CMAX : m_cnt + 1) : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // scheduler acknowledge and per-cycle comparison
    always @(negedge clk) begin
        int e_op, e_mode;
        bit e_req, e_stall, e_ack, e_deny, sr_res;
        ack = (m_phase != 0) && (m_wait >= ack_lat);
        #1;
        if (rst_n && !done) begin
            e_req   = (m_phase != 0);
            e_op    = (m_phase == 1) ? 2 * (m_tgt - 1) : 2 * (m_mode - 1) + 1;
            e_mode  = (m_phase == 1) ? 0 : m_mode;
            e_stall = !(m_mode == 0 && m_phase == 0);
            sr_res  = (m_mode == 2 && m_phase == 0);
            e_ack   = sr_res && hw_req;
            e_deny  = hw_req && pend && !sr_res;
            chk(cmd_req == e_req, "R4 cmd_req", cmd_req, e_req);
            if (e_req) chk(cmd_op == e_op[2:0], "R4 cmd_op", cmd_op, e_op);
            chk(lp_mode == e_mode[2:0], "R11 lp_mode", lp_mode, e_mode);
            chk(stall == e_stall, "R3 traffic_stall", stall, e_stall);
            chk(hw_ack == e_ack, "R7 hw_lp_ack", hw_ack, e_ack);
            chk(hw_deny == e_deny, "R7 hw_lp_deny", hw_deny, e_deny);
            if (cmd_req && cmd_op == 3'd1) seen_pd_out = 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL R4 watchdog: cycles=%0d expected<%0d", cyc, WD);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic send_txn();
        arrive = 1;
        step(1);
        for (int i = 0; i < 60 && stall; i++) step(1);
        arrive = 0;
    endtask

    initial begin
        pd_en = 1;
        step(3);
        rst_n = 1;
        #1;
        chk(lp_mode == 3'd0, "R1 mode", lp_mode, 0);
        chk(!cmd_req && !stall, "R1 req/stall", {cmd_req, stall}, 0);
        chk(!hw_ack && !hw_deny, "R1 hw", {hw_ack, hw_deny}, 0);
        step(1);

        // R2: idle power-down
        step(3);
        chk(lp_mode == 3'd0, "R2 not yet", lp_mode, 0);
        step(12);
        chk(lp_mode == 3'd1, "R2 power-down", lp_mode, 1);
        // R3: wake on arrival
        send_txn();
        chk(lp_mode == 3'd0 && !stall, "R3 back to normal", lp_mode, 0);

        // R5: power-down then self-refresh
        sr_en = 1; seen_pd_out = 0;
        step(30);
        chk(lp_mode == 3'd2, "R5 self-refresh", lp_mode, 2);
        chk(seen_pd_out, "R5 pd exit first", seen_pd_out, 1);
        send_txn();
        chk(lp_mode == 3'd0, "R3 sr wake", lp_mode, 0);

        // R6: software self-refresh overrides arrivals
        sr_en = 0; pd_en = 0;
        sw_sr = 1; step(8);
        arrive = 1; step(10);
        chk(lp_mode == 3'd2, "R6 held in sr", lp_mode, 2);
        sw_sr = 0; step(1);
        for (int i = 0; i < 30 && stall; i++) step(1);
        arrive = 0;
        chk(lp_mode == 3'd0, "R6 released", lp_mode, 0);

        // R7: hardware handshake
        pend = 1; hw_req = 1; step(3);
        chk(hw_deny == 1'b1, "R7 deny", hw_deny, 1);
        chk(lp_mode == 3'd0, "R7 no entry", lp_mode, 0);
        pend = 0; step(8);
        chk(hw_ack == 1'b1 && lp_mode == 3'd2, "R7 ack in sr", {hw_ack, lp_mode}, 6'h12);
        hw_req = 0; step(8);
        chk(lp_mode == 3'd0, "R7 exit on drop", lp_mode, 0);

        // R8: clock stop only for low-power kinds
        ack_lat = 0; cs_en = 1; kind = 2'd0;
        step(20);
        chk(lp_mode == 3'd0, "R8 kind0 no cs", lp_mode, 0);
        kind = 2'd2; step(20);
        chk(lp_mode == 3'd3, "R8 clock stop", lp_mode, 3);
        send_txn();
        chk(lp_mode == 3'd0, "R3 cs wake", lp_mode, 0);

        // R9: deep power-down
        cs_en = 0; kind = 2'd0; sw_dpd = 1; step(10);
        chk(lp_mode == 3'd0, "R9 wrong kind", lp_mode, 0);
        sw_dpd = 0; step(1);
        kind = 2'd1; sw_dpd = 1; step(10);
        chk(lp_mode == 3'd4, "R9 enter", lp_mode, 4);
        arrive = 1; step(10);
        chk(lp_mode == 3'd4 && stall, "R9 arrival ignored", lp_mode, 4);
        sw_dpd = 0; step(1);
        for (int i = 0; i < 30 && stall; i++) step(1);
        arrive = 0;
        chk(lp_mode == 3'd0, "R9 exit", lp_mode, 0);

        // R10: enables and priority
        ack_lat = 4; step(40);
        chk(lp_mode == 3'd0, "R10 all disabled", lp_mode, 0);
        kind = 2'd2; pd_en = 1; cs_en = 1; cs_thr = 5'd4;
        step(15);
        chk(lp_mode == 3'd3, "R10 cs over pd", lp_mode, 3);
        send_txn();
        cs_en = 0; sr_en = 1; sr_thr = 5'd4;
        step(15);
        chk(lp_mode == 3'd2, "R10 sr over pd", lp_mode, 2);
        send_txn();

        // R12: clearing and saturation
        ack_lat = 2; pd_en = 0; sr_thr = 5'd10;
        for (int k = 0; k < 5; k++) begin
            step(8); pend = 1; step(1); pend = 0;
        end
        chk(lp_mode == 3'd0, "R12 pending clears", lp_mode, 0);
        pend = 1; step(1); pend = 0;
        sr_thr = 5'd31; step(30);
        chk(lp_mode == 3'd0, "R12 below ceiling", lp_mode, 0);
        step(40);
        chk(lp_mode == 3'd2, "R12 saturated hit", lp_mode, 2);
        send_txn();
        step(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule